// File: doc/BRIEF.md
# Binary Field Inverter Using Fourth-Power Stages

This block returns the multiplicative inverse of a nonzero element of GF(2^m), with elements held in polynomial basis: bit i of a word is the coefficient of x^i. The field and its reduction polynomial are fixed at elaboration. The parameter `POLY` holds the low m coefficients of the reduction polynomial, and the x^m term is implied. The inverse is a^(2^m-2). The block builds it with the Itoh-Tsujii scheme, which needs only field multiplications and linear maps.

The linear map used most is the fourth power. It is two squarings folded into one constant binary matrix, and that matrix is computed from `POLY` at elaboration. Several fourth-power circuits sit in a cascade. In each power cycle a selector picks how many of them apply. A single field multiplier is shared across all steps. A small controller walks an addition chain fixed at elaboration. The chain comes from the binary expansion of h = floor((m-1)/2). In any one cycle either the multiplier or the power block works, never both. When m-1 is odd, a closing step raises to the fourth power and multiplies by a^2. When m-1 is even, the closing step is one squaring.

A caller holds `go_i` high for one cycle while `elem_i` carries the operand. The block then raises `ready_o` for exactly one cycle, and `inv_o` holds the inverse from that cycle until the next accepted request. Inversion of zero is undefined.

Top module: `gf2m_quad_inverter`

## Requirements
- R1: After synchronous reset, `ready_o` is 0 and `inv_o` is 0.
- R2: For a field where m-1 is odd (for example m=8 with POLY=8'h1B, or m=4 with POLY=4'h3), `inv_o` multiplied by the accepted operand in the field equals 1, for every nonzero operand.
- R3: For a field where m-1 is even (for example m=13 with POLY=13'h001B), `inv_o` multiplied by the accepted operand equals 1, for every nonzero operand.
- R4: `ready_o` is a single-cycle pulse, and it is raised only when the block returns to idle.
- R5: Counted from the clock edge that accepts `go_i`, `ready_o` is seen after exactly L edges. With h = floor((m-1)/2) and t the index of the top set bit of h, L = 2 + sum over i = t-1 down to 0 of (ceil((h>>(i+1))/NQ) + 1 + 2*h[i]), plus 2 when m-1 is odd and 1 when it is even.
- R6: A `go_i` pulse that arrives while an inversion is running is ignored: the running result and its latency are unchanged.
- R7: `inv_o` stays stable from the `ready_o` cycle until the next `go_i` is accepted.
- R8: The multiplier and the power block are never both active in the same cycle.
- R9: Every fourth-power cycle applies at least 1 and at most NQ cascaded stages.
- R10: The operand is captured on the edge that accepts `go_i`. Later changes on `elem_i` do not affect the result.
- R11: In GF(2^4) with reduction x^4+x+1 (POLY=4'h3), the inverse of x^3+x^2+1 (4'hD) is x^2 (4'h4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | Starts an inversion when the block is idle |
| elem_i | input | M | Operand, polynomial basis, must be nonzero |
| inv_o | output | M | Inverse, valid from the `ready_o` cycle |
| ready_o | output | 1 | One-cycle flag that the inverse is valid |

## Verification
The assertions assume two things. The first is that `go_i` matters only in the idle state, so a pulse while the block is busy must leave the captured operand and the controller untouched. The second is that the operand is never zero. The stimulus sweeps every nonzero element of three small fields, so zero is never applied. At chosen points in each sweep it raises a stray `go_i` mid-computation and flips `elem_i`. Each product is checked against 1 with an independent bit-serial multiplier, and each latency is checked against the chain formula.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

    localparam int MAXW = 64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SQA,
        ST_MINIT,
        ST_POW,
        ST_MUL,
        ST_FPOW,
        ST_FMUL
    } inv_state_e;

    typedef enum logic [1:0] {
        PSRC_OPND,
        PSRC_MOUT,
        PSRC_PWR
    } pow_src_e;

    typedef enum logic [1:0] {
        MSEL_OPND,
        MSEL_MOUT,
        MSEL_G1,
        MSEL_ASQ
    } mul_sel_e;

    typedef enum logic {
        STEP_DBL,
        STEP_ADD
    } step_kind_e;

    typedef struct packed {
        logic     en;
        pow_src_e src;
        logic     square;
    } pow_cmd_t;

    typedef struct packed {
        logic     en;
        mul_sel_e sel;
    } mul_cmd_t;

    // multiply by x modulo the field polynomial (x^m term implied)
    function automatic logic [MAXW-1:0] gf_mulx(input logic [MAXW-1:0] v,
                                                input int m,
                                                input logic [MAXW-1:0] poly);
        logic [MAXW-1:0] mask;
        logic            hi;
        mask = (64'd1 << m) - 64'd1;
        hi   = v[m-1];
        return ((v << 1) & mask) ^ (hi ? poly : '0);
    endfunction

    // x^e modulo the field polynomial
    function automatic logic [MAXW-1:0] gf_xpow(input int e, input int m,
                                                input logic [MAXW-1:0] poly);
        logic [MAXW-1:0] r;
        r = 64'd1;
        for (int i = 0; i < e; i++) r = gf_mulx(r, m, poly);
        return r;
    endfunction

endpackage

// File: rtl/gf_mul_comb.sv
module gf_mul_comb #(
    parameter int           M    = 8,
    parameter logic [M-1:0] POLY = 8'h1B
) (
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    output logic [M-1:0] p_o
);
    // shift-and-add product, reduced on every step
    always_comb begin
        logic [M-1:0] acc;
        acc = '0;
        for (int i = M - 1; i >= 0; i--) begin
            acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? POLY : '0);
            if (b_i[i]) acc = acc ^ a_i;
        end
        p_o = acc;
    end
endmodule

// File: rtl/gf_quad_power_block.sv
module gf_quad_power_block
    import gfinv_pkg::*;
#(
    parameter int           M    = 8,
    parameter logic [M-1:0] POLY = 8'h1B,
    parameter int           NQ   = 2,
    localparam int          SW   = $clog2(NQ + 1)
) (
    input  logic [M-1:0]  din_i,
    input  logic          square_i,
    input  logic [SW-1:0] nsel_i,
    output logic [M-1:0]  dout_o
);
    localparam logic [MAXW-1:0] POLY64 = MAXW'(POLY);

    // column j of the map holds x^(e*j) mod P
    function automatic logic [M-1:0][M-1:0] build_mat(input int e);
        logic [M-1:0][M-1:0] mat;
        logic [MAXW-1:0]     col;
        for (int j = 0; j < M; j++) begin
            col    = gf_xpow(e * j, M, POLY64);
            mat[j] = col[M-1:0];
        end
        return mat;
    endfunction

    function automatic logic [M-1:0] mat_apply(input logic [M-1:0] v,
                                               input logic [M-1:0][M-1:0] mat);
        logic [M-1:0] t;
        t = '0;
        for (int j = 0; j < M; j++) if (v[j]) t = t ^ mat[j];
        return t;
    endfunction

    localparam logic [M-1:0][M-1:0] SQ_MAT = build_mat(2);
    localparam logic [M-1:0][M-1:0] QD_MAT = build_mat(4);

    logic [M-1:0] stg [NQ+1];

    assign stg[0] = din_i;

    for (genvar s = 0; s < NQ; s++) begin : g_quad
        assign stg[s+1] = mat_apply(stg[s], QD_MAT);
    end

    always_comb begin
        dout_o = stg[1];
        for (int k = 1; k <= NQ; k++) begin
            if (int'(nsel_i) == k) dout_o = stg[k];
        end
        if (square_i) dout_o = mat_apply(din_i, SQ_MAT);
    end
endmodule

// File: rtl/gf2m_quad_inverter.sv
module gf2m_quad_inverter
    import gfinv_pkg::*;
#(
    parameter int           M    = 8,
    parameter logic [M-1:0] POLY = 8'h1B,
    parameter int           NQ   = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_i,
    input  logic [M-1:0] elem_i,
    output logic [M-1:0] inv_o,
    output logic         ready_o
);
    localparam int  B        = M - 1;
    localparam int  H        = B / 2;
    localparam bit  ODD_B    = (B % 2) == 1;
    localparam int  HB       = $clog2(H + 1) - 1;
    localparam bit  NO_CHAIN = (HB == 0);
    localparam int  IW       = (HB > 0) ? $clog2(HB + 1) : 1;
    localparam int  RW       = $clog2(H + 1);
    localparam int  SW       = $clog2(NQ + 1);
    localparam logic [RW-1:0] H_V  = RW'(H);
    localparam logic [RW-1:0] REM0 = RW'(H >> HB);

    inv_state_e   state;
    step_kind_e   kind;
    logic [IW-1:0] idx;
    logic [RW-1:0] rem;
    logic          first;
    logic [M-1:0]  opnd_r, pwr, mout, g1, asq;

    pow_cmd_t      pcmd;
    mul_cmd_t      mcmd;
    logic [SW-1:0] nsel;
    logic [RW-1:0] rem_next;
    logic [M-1:0]  pow_in, pow_out, mul_b, mul_out;

    // one unit per cycle: the state alone picks power or multiply
    always_comb begin
        pcmd = '{en: 1'b0, src: PSRC_MOUT, square: 1'b0};
        mcmd = '{en: 1'b0, sel: MSEL_MOUT};
        nsel = SW'(1);
        case (state)
            ST_SQA:   pcmd = '{en: 1'b1, src: PSRC_OPND, square: 1'b1};
            ST_MINIT: mcmd = '{en: 1'b1, sel: MSEL_OPND};
            ST_POW: begin
                pcmd = '{en: 1'b1, src: (first ? PSRC_MOUT : PSRC_PWR), square: 1'b0};
                nsel = (int'(rem) > NQ) ? SW'(NQ) : SW'(rem);
            end
            ST_MUL:   mcmd = '{en: 1'b1, sel: (kind == STEP_DBL) ? MSEL_MOUT : MSEL_G1};
            ST_FPOW:  pcmd = '{en: 1'b1, src: PSRC_MOUT, square: !ODD_B};
            ST_FMUL:  mcmd = '{en: 1'b1, sel: MSEL_ASQ};
            default: ;
        endcase
    end

    always_comb begin
        case (pcmd.src)
            PSRC_OPND: pow_in = opnd_r;
            PSRC_PWR:  pow_in = pwr;
            default:   pow_in = mout;
        endcase
        case (mcmd.sel)
            MSEL_OPND: mul_b = opnd_r;
            MSEL_G1:   mul_b = g1;
            MSEL_ASQ:  mul_b = asq;
            default:   mul_b = mout;
        endcase
    end

    assign rem_next = rem - RW'(nsel);

    gf_quad_power_block #(.M(M), .POLY(POLY), .NQ(NQ)) u_pow (
        .din_i   (pow_in),
        .square_i(pcmd.square),
        .nsel_i  (nsel),
        .dout_o  (pow_out)
    );

    gf_mul_comb #(.M(M), .POLY(POLY)) u_mul (
        .a_i(pwr),
        .b_i(mul_b),
        .p_o(mul_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            kind    <= STEP_DBL;
            idx     <= '0;
            rem     <= '0;
            first   <= 1'b0;
            opnd_r  <= '0;
            pwr     <= '0;
            mout    <= '0;
            g1      <= '0;
            asq     <= '0;
            ready_o <= 1'b0;
        end else begin
            ready_o <= 1'b0;
            if (pcmd.en) pwr  <= pow_out;
            if (mcmd.en) mout <= mul_out;
            case (state)
                ST_IDLE: begin
                    if (go_i) begin
                        opnd_r <= elem_i;
                        state  <= ST_SQA;
                    end
                end
                ST_SQA: state <= ST_MINIT;
                ST_MINIT: begin
                    g1  <= mul_out;
                    asq <= pwr;
                    if (NO_CHAIN) begin
                        state <= ST_FPOW;
                    end else begin
                        idx   <= IW'(HB - 1);
                        kind  <= STEP_DBL;
                        rem   <= REM0;
                        first <= 1'b1;
                        state <= ST_POW;
                    end
                end
                ST_POW: begin
                    rem   <= rem_next;
                    first <= 1'b0;
                    if (rem_next == '0) state <= ST_MUL;
                end
                ST_MUL: begin
                    if (kind == STEP_DBL && H_V[idx]) begin
                        kind  <= STEP_ADD;
                        rem   <= RW'(1);
                        first <= 1'b1;
                        state <= ST_POW;
                    end else if (idx == '0) begin
                        state <= ST_FPOW;
                    end else begin
                        idx   <= idx - IW'(1);
                        kind  <= STEP_DBL;
                        rem   <= H_V >> idx;
                        first <= 1'b1;
                        state <= ST_POW;
                    end
                end
                ST_FPOW: begin
                    if (ODD_B) begin
                        state <= ST_FMUL;
                    end else begin
                        state   <= ST_IDLE;
                        ready_o <= 1'b1;
                    end
                end
                ST_FMUL: begin
                    state   <= ST_IDLE;
                    ready_o <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign inv_o = ODD_B ? mout : pwr;

    AST_ONE_UNIT: assert property (@(posedge clk) disable iff (rst)
        !(pcmd.en && mcmd.en)); // R8

    AST_CASCADE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POW) |-> (int'(nsel) >= 1 && int'(nsel) <= NQ)); // R9

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> !ready_o); // R4

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (state == ST_IDLE)); // R4

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !go_i) |=> $stable(inv_o)); // R7

    AST_BUSY_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(opnd_r)); // R10

    AST_GO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && go_i) |=> (state == ST_SQA)); // R6
endmodule

// File: tb/test_gf2m_quad_inverter.sv
module test_gf2m_quad_inverter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic        go [3];
    logic [15:0] op [3];
    logic [7:0]  res_a;
    logic [3:0]  res_b;
    logic [12:0] res_c;
    logic [2:0]  dn;

    gf2m_quad_inverter i_gf2m_quad_inverter (
        .clk(clk), .rst(rst), .go_i(go[0]), .elem_i(op[0][7:0]),
        .inv_o(res_a), .ready_o(dn[0]));

    gf2m_quad_inverter #(.M(4), .POLY(4'h3), .NQ(1)) i_gf2m_quad_inverter_m4 (
        .clk(clk), .rst(rst), .go_i(go[1]), .elem_i(op[1][3:0]),
        .inv_o(res_b), .ready_o(dn[1]));

    gf2m_quad_inverter #(.M(13), .POLY(13'h001B), .NQ(2)) i_gf2m_quad_inverter_m13 (
        .clk(clk), .rst(rst), .go_i(go[2]), .elem_i(op[2][12:0]),
        .inv_o(res_c), .ready_o(dn[2]));

    function automatic logic [15:0] get_res(input int k);
        case (k)
            0:       return {8'h0, res_a};
            1:       return {12'h0, res_b};
            default: return {3'h0, res_c};
        endcase
    endfunction

    // bit-serial reference product
    function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] b,
                                            input int m, input logic [15:0] poly);
        logic [15:0] acc, mask;
        mask = (16'd1 << m) - 16'd1;
        acc  = '0;
        for (int i = m - 1; i >= 0; i--) begin
            acc = ((acc << 1) & mask) ^ (acc[m-1] ? poly : 16'h0);
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

    function automatic int exp_lat(input int m, input int nq);
        int h, t, l;
        h = (m - 1) / 2;
        t = $clog2(h + 1) - 1;
        l = 2;
        for (int i = t - 1; i >= 0; i--) begin
            l += ((h >> (i + 1)) + nq - 1) / nq + 1;
            if (((h >> i) & 1) == 1) l += 2;
        end
        l += ((m - 1) % 2 == 1) ? 2 : 1;
        return l;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_inv(input int k, input int m, input logic [15:0] poly,
                           input int nq, input logic [15:0] a, input bit poke);
        int cnt;
        logic [15:0] r, mask;
        mask = (16'd1 << m) - 16'd1;
        @(negedge clk);
        op[k] = a;
        go[k] = 1'b1;
        @(negedge clk);
        go[k] = 1'b0;
        if (poke) op[k] = ~a & mask;
        cnt = 0;
        while (!dn[k] && cnt < 100) begin
            @(negedge clk);
            cnt++;
            if (poke) go[k] = (cnt == 2);
        end
        go[k] = 1'b0;
        chk(cnt == exp_lat(m, nq), poke ? "R6 latency with stray go" : "R5 latency",
            cnt, exp_lat(m, nq));
        r = get_res(k);
        chk(ref_mul(a, r, m, poly) == 16'd1,
            poke ? "R10 operand change ignored" :
                   (((m - 1) % 2 == 1) ? "R2 product odd m-1" : "R3 product even m-1"),
            ref_mul(a, r, m, poly), 1);
        @(negedge clk);
        chk(dn[k] == 1'b0, "R4 ready single pulse", dn[k], 0);
        chk(get_res(k) == r, "R7 result held", get_res(k), r);
    endtask

    initial begin
        go = '{default: 1'b0};
        op = '{default: 16'h0};
        repeat (4) @(negedge clk);
        chk(dn == 3'b000, "R1 ready low after reset", dn, 0);
        chk(res_a == 8'h0 && res_b == 4'h0 && res_c == 13'h0, "R1 result zero after reset",
            {res_a, res_b, res_c}, 0);
        rst = 1'b0;
        fork
            begin
                for (int a = 1; a < 256; a++)
                    run_inv(0, 8, 16'h001B, 2, 16'(a), (a % 17) == 0);
            end
            begin
                for (int a = 1; a < 16; a++)
                    run_inv(1, 4, 16'h0003, 1, 16'(a), a == 5);
                run_inv(1, 4, 16'h0003, 1, 16'h000D, 1'b0);
                chk(res_b == 4'h4, "R11 inverse of x^3+x^2+1", res_b, 4'h4);
            end
            begin
                for (int a = 1; a < 8192; a++)
                    run_inv(2, 13, 16'h001B, 2, 16'(a), (a % 97) == 0);
            end
        join
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule